// File: doc/BRIEF.md
# Chained Dot-Matrix Display Write Sequencer

This block is the host-side driver for a daisy chain of serial dot-matrix display devices. It turns two kinds of host request into correctly ordered pin activity on four lines: a register-select level, an active-low chip enable, a serial shift clock and a serial data line. A frame request shifts one full dot pattern of `N_DEV*DOTS_PER_DEV` bits, pulled one at a time from a valid/ready bit stream. A control request shifts one 8-bit control word, most significant bit first. The word is sent either once per device when the chain is in serial mode, or once in total when the devices pass their input straight through.

The shift clock is derived from the system clock. Every high and low phase, and every setup gap, lasts at least `HALF_CYC` system cycles. With a 100 MHz system clock and `HALF_CYC` = 10, the shift clock runs at 5 MHz with 100 ns phases. Each transfer ends by raising chip enable while the shift clock is still high, then dropping the shift clock, which makes the devices latch the new data. After reset the block runs its own start-up recipe: an all-zero dot frame, then control word 0 with the sleep-exit bit set and the configured brightness. Only after that does it accept host requests.

Top module: `disp_wr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip enable is high, the shift clock is low and `req_ready` is low.
- R2: After reset, the block first shifts `N_DEV*DOTS_PER_DEV` zero bits with select low. It then shifts the 8-bit word {0, 1, INIT_BRIGHT[5:0]} (bit 7 = 0 chooses control word 0, bit 6 = 1 leaves sleep) `N_DEV` times, MSB first, with select high. Only then does it raise `req_ready`. It gives no `done` pulse for this start-up sequence.
- R3: The select line reaches its new level at least `HALF_CYC` system cycles before chip enable falls, and it does not change while chip enable is low.
- R4: The shift clock is low whenever chip enable falls. Every rising edge of the shift clock happens while chip enable is low.
- R5: Every high phase and every low phase of the shift clock lasts at least `HALF_CYC` system cycles.
- R6: The data line changes only while the shift clock is low.
- R7: A frame request (`req_kind` = 0) produces exactly `N_DEV*DOTS_PER_DEV` rising edges with select low. The data bit at edge k is the k-th bit accepted on the stream. `bit_ready` is high only while chip enable is low and the shift clock is low.
- R8: A control request (`req_kind` = 1) with `req_simul` = 0 produces `8*N_DEV` rising edges with select high. The data line at edge k carries bit `7 - (k mod 8)` of `req_ctl`.
- R9: A control request with `req_simul` = 1 produces exactly 8 rising edges, carrying `req_ctl` MSB first.
- R10: Each transfer ends with chip enable rising while the shift clock is high, then the shift clock falling while chip enable is high. After that, `done` pulses for one cycle and `req_ready` rises.
- R11: `req_valid` has no effect while `req_ready` is low. A request held during a transfer starts no further transfer and gives no extra `done` pulse.
- R12: While the stream holds `bit_valid` low, the shift clock stays low and no edge is produced. The transfer resumes with no bit lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer (taken when `req_ready` is high) |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 1 | 0 = dot frame, 1 = control word |
| req_ctl | input | 8 | Control word to send |
| req_simul | input | 1 | 1 = send control word once (pass-through chain), 0 = once per device |
| bit_valid | input | 1 | Frame bit on `bit_data` is valid |
| bit_data | input | 1 | Frame bit, left-most character first |
| bit_ready | output | 1 | Sequencer takes a frame bit this cycle |
| done | output | 1 | One-cycle pulse when a host transfer has latched |
| disp_rs | output | 1 | Register select to the chain (0 dots, 1 control) |
| disp_ce_n | output | 1 | Active-low chip enable to the chain |
| disp_clk | output | 1 | Serial shift clock to the chain |
| disp_din | output | 1 | Serial data to the first device of the chain |

## Verification
Some ordering rules are checked by the assertions on every cycle: the minimum high and low phase widths, the select setup and hold around chip enable, data changing only while the clock is low, clock edges only inside the enable window, and the stream handshake only while waiting at a low clock. Other behaviour is visible only from the bench's pin-level scenarios. These cover bit counts and bit order per request kind, the content of the start-up recipe, the latch ordering at the end of each transfer, stream stalls, and requests made while the block is busy. The bench rebuilds every transfer from the pins and compares it with the bits it expects.

// File: rtl/dws_pkg.sv
package dws_pkg;

    // sequencer phases, in the order a transfer walks through them
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RS    = 3'd1,  // select settling, enable high
        S_CEF   = 3'd2,  // enable low, clock low, setup gap
        S_LOAD  = 3'd3,  // clock low, fetch next bit
        S_LOW   = 3'd4,  // clock low, bit on the line
        S_HIGH  = 3'd5,  // clock high
        S_CER   = 3'd6,  // enable high, clock still high
        S_LATCH = 3'd7   // clock low with enable high: devices latch
    } seq_state_e;

    typedef enum logic {
        K_DOTS = 1'b0,
        K_CTRL = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic [7:0] cur;
        logic [7:0] keep;
        logic [2:0] pos;
    } cw_state_t;

endpackage

// File: rtl/dws_halfcnt.sv
module dws_halfcnt #(
    parameter int HALF_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int W = $clog2(HALF_CYC + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = W'(HALF_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(HALF_CYC - 1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dws_cwshift.sv
module dws_cwshift
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    output logic       msb
);
    cw_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cur  = load_byte;
            s_d.keep = load_byte;
            s_d.pos  = 3'd0;
        end else if (shift) begin
            if (s_q.pos == 3'd7) begin
                // one word done: start the copy for the next device
                s_d.cur = s_q.keep;
                s_d.pos = 3'd0;
            end else begin
                s_d.cur = {s_q.cur[6:0], 1'b0};
                s_d.pos = s_q.pos + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign msb = s_q.cur[7];

endmodule

// File: rtl/disp_wr_seq.sv
module disp_wr_seq
    import dws_pkg::*;
#(
    parameter int         N_DEV        = 2,
    parameter int         DOTS_PER_DEV = 160,
    parameter int         HALF_CYC     = 10,
    parameter logic [5:0] INIT_BRIGHT  = 6'b001101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_kind,
    input  logic [7:0] req_ctl,
    input  logic       req_simul,
    input  logic       bit_valid,
    input  logic       bit_data,
    output logic       bit_ready,
    output logic       done,
    output logic       disp_rs,
    output logic       disp_ce_n,
    output logic       disp_clk,
    output logic       disp_din
);
    localparam int         FRAME_BITS = N_DEV * DOTS_PER_DEV;
    localparam int         CW_BITS    = 8;
    localparam int         CW_CHAIN   = N_DEV * CW_BITS;
    localparam int         CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [7:0] INIT_WORD  = {1'b0, 1'b1, INIT_BRIGHT};

    typedef struct packed {
        seq_state_e       st;
        logic             rs;
        logic             din;
        logic             kind;
        logic             zero;
        logic             init;
        logic             init_ctl;
        logic [CNT_W-1:0] left;
        logic             done;
    } seq_t;

    seq_t r_d, r_q;

    logic       restart;
    logic       expired;
    logic       cw_load;
    logic [7:0] cw_byte;
    logic       cw_shift;
    logic       cw_msb;
    logic       take_bit;

    dws_halfcnt #(
        .HALF_CYC(HALF_CYC)
    ) i_halfcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .expired(expired)
    );

    dws_cwshift i_cwshift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cw_load),
        .load_byte(cw_byte),
        .shift    (cw_shift),
        .msb      (cw_msb)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        restart   = 1'b0;
        cw_load   = 1'b0;
        cw_byte   = '0;
        cw_shift  = 1'b0;
        bit_ready = 1'b0;
        take_bit  = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.rs   = req_kind;
                    r_d.kind = req_kind;
                    r_d.zero = 1'b0;
                    if (req_kind == K_CTRL) begin
                        r_d.left = req_simul ? CNT_W'(CW_BITS) : CNT_W'(CW_CHAIN);
                        cw_load  = 1'b1;
                        cw_byte  = req_ctl;
                    end else begin
                        r_d.left = CNT_W'(FRAME_BITS);
                    end
                    r_d.st  = S_RS;
                    restart = 1'b1;
                end
            end
            S_RS: begin
                if (expired) begin
                    r_d.st  = S_CEF;
                    restart = 1'b1;
                end
            end
            S_CEF: begin
                if (expired) begin
                    r_d.st = S_LOAD;
                end
            end
            S_LOAD: begin
                if (r_q.kind == K_CTRL || r_q.zero) begin
                    take_bit = 1'b1;
                end else begin
                    bit_ready = 1'b1;
                    take_bit  = bit_valid;
                end
                if (take_bit) begin
                    if (r_q.kind == K_CTRL) begin
                        r_d.din  = cw_msb;
                        cw_shift = 1'b1;
                    end else begin
                        r_d.din = r_q.zero ? 1'b0 : bit_data;
                    end
                    r_d.left = r_q.left - 1'b1;
                    r_d.st   = S_LOW;
                    restart  = 1'b1;
                end
            end
            S_LOW: begin
                if (expired) begin
                    r_d.st  = S_HIGH;
                    restart = 1'b1;
                end
            end
            S_HIGH: begin
                if (expired) begin
                    if (r_q.left == '0) begin
                        r_d.st  = S_CER;
                        restart = 1'b1;
                    end else begin
                        r_d.st = S_LOAD;
                    end
                end
            end
            S_CER: begin
                if (expired) begin
                    r_d.st  = S_LATCH;
                    restart = 1'b1;
                end
            end
            S_LATCH: begin
                if (expired) begin
                    if (r_q.init && !r_q.init_ctl) begin
                        // start-up step two: wake the chain
                        r_d.rs       = 1'b1;
                        r_d.kind     = K_CTRL;
                        r_d.zero     = 1'b0;
                        r_d.init_ctl = 1'b1;
                        r_d.left     = CNT_W'(CW_CHAIN);
                        cw_load      = 1'b1;
                        cw_byte      = INIT_WORD;
                        r_d.st       = S_RS;
                        restart      = 1'b1;
                    end else if (r_q.init) begin
                        r_d.init = 1'b0;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= S_RS;
            r_q.rs       <= 1'b0;
            r_q.din      <= 1'b0;
            r_q.kind     <= K_DOTS;
            r_q.zero     <= 1'b1;
            r_q.init     <= 1'b1;
            r_q.init_ctl <= 1'b0;
            r_q.left     <= CNT_W'(FRAME_BITS);
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == S_IDLE);
    assign done      = r_q.done;
    assign disp_rs   = r_q.rs;
    assign disp_din  = r_q.din;
    assign disp_ce_n = !(r_q.st == S_CEF || r_q.st == S_LOAD ||
                         r_q.st == S_LOW || r_q.st == S_HIGH);
    assign disp_clk  = (r_q.st == S_HIGH || r_q.st == S_CER);

endmodule

// File: rtl/dws_check.sv
module dws_check #(
    parameter int HALF_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic bit_ready,
    input logic done,
    input logic disp_rs,
    input logic disp_ce_n,
    input logic disp_clk,
    input logic disp_din
);
    logic [15:0] hi_run_q, lo_run_q, rs_age_q;
    logic        rs_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q  <= '0;
            lo_run_q  <= '0;
            rs_age_q  <= '0;
            rs_prev_q <= 1'b0;
        end else begin
            if (disp_clk) begin
                if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 16'd1;
                lo_run_q <= '0;
            end else begin
                if (lo_run_q != 16'hFFFF) lo_run_q <= lo_run_q + 16'd1;
                hi_run_q <= '0;
            end
            rs_prev_q <= disp_rs;
            if (disp_rs != rs_prev_q) begin
                rs_age_q <= 16'd1;
            end else if (rs_age_q != 16'hFFFF) begin
                rs_age_q <= rs_age_q + 16'd1;
            end
        end
    end

    p_rs_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_ce_n) |-> rs_age_q >= 16'(HALF_CYC));

    p_rs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ce_n && !$fell(disp_ce_n)) |-> $stable(disp_rs));

    p_ce_fall_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_ce_n) |-> !disp_clk);

    p_rise_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_clk) |-> !disp_ce_n);

    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_clk) |-> hi_run_q >= 16'(HALF_CYC));

    p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_clk) |-> lo_run_q >= 16'(HALF_CYC));

    p_din_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_din) |-> !disp_clk);

    p_stream_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |-> (!disp_ce_n && !disp_clk && !disp_rs));

    p_done_after_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_ce_n && !disp_clk && req_ready));

    p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (disp_ce_n && !disp_clk));

endmodule

bind disp_wr_seq dws_check #(
    .HALF_CYC(HALF_CYC)
) i_dws_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .bit_ready(bit_ready),
    .done     (done),
    .disp_rs  (disp_rs),
    .disp_ce_n(disp_ce_n),
    .disp_clk (disp_clk),
    .disp_din (disp_din)
);

// File: tb/test_disp_wr_seq.sv
module test_disp_wr_seq;
    localparam int         N_DEV  = 2;
    localparam int         DOTS   = 160;
    localparam int         HALF   = 10;
    localparam int         FBITS  = N_DEV * DOTS;
    localparam logic [5:0] BRIGHT = 6'b101101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_kind = 1'b0;
    logic [7:0] req_ctl = '0;
    logic       req_simul = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready;
    logic       done;
    logic       disp_rs, disp_ce_n, disp_clk, disp_din;

    always #5 clk = ~clk;

    disp_wr_seq #(
        .N_DEV(N_DEV), .DOTS_PER_DEV(DOTS), .HALF_CYC(HALF), .INIT_BRIGHT(BRIGHT)
    ) i_disp_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_ctl(req_ctl), .req_simul(req_simul),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
        .done(done), .disp_rs(disp_rs), .disp_ce_n(disp_ce_n),
        .disp_clk(disp_clk), .disp_din(disp_din)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- pin monitor, sampled mid-cycle ----------------
    logic cap [0:1023];
    int   cap_n = 0, cap_ones = 0;
    logic cap_rs = 1'b0;
    int   log_n [0:63];
    int   log_ones [0:63];
    logic log_rs [0:63];
    int   nlog = 0, done_cnt = 0;
    int   stray_rise = 0, rs_moved = 0, ce_fall_hi = 0, din_bad = 0, ce_rise_lo = 0;
    int   min_hi = 1000000, min_lo = 1000000, min_rs_age = 1000000;
    int   run_len = 0, rs_age = 0;
    logic p_clk = 1'b0, p_ce = 1'b1, p_rs = 1'b0, p_din = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (disp_rs != p_rs) rs_age = 0; else rs_age++;
            if (p_ce && !disp_ce_n) begin
                cap_n = 0; cap_ones = 0; cap_rs = disp_rs;
                if (disp_clk) ce_fall_hi++;
                if (rs_age + 1 < min_rs_age) min_rs_age = rs_age + 1;
            end
            if (!disp_ce_n && disp_rs != cap_rs) rs_moved++;
            if (!p_ce && disp_ce_n && !disp_clk) ce_rise_lo++;
            if (disp_din != p_din && (disp_clk || p_clk)) din_bad++;
            if (disp_clk == p_clk) run_len++;
            else begin
                if (p_clk && run_len < min_hi) min_hi = run_len;
                if (!p_clk && run_len < min_lo) min_lo = run_len;
                run_len = 1;
            end
            if (!p_clk && disp_clk) begin
                if (disp_ce_n) stray_rise++;
                if (cap_n < 1024) cap[cap_n] = disp_din;
                cap_n++;
                if (disp_din) cap_ones++;
            end
            if (p_clk && !disp_clk && disp_ce_n && nlog < 64) begin
                log_n[nlog] = cap_n; log_ones[nlog] = cap_ones; log_rs[nlog] = cap_rs;
                nlog++;
            end
            if (done) done_cnt++;
            p_clk = disp_clk; p_ce = disp_ce_n; p_rs = disp_rs; p_din = disp_din;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic cw_bit(input logic [7:0] w, input int k);
        return w[7 - (k % 8)];
    endfunction

    logic fb [0:FBITS-1];

    task automatic issue(input logic kind, input logic [7:0] w, input logic simul);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_ctl = w; req_simul = simul;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt <= d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic stream(input int max_stall, input int hold_at);
        for (int i = 0; i < FBITS; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            if (i == hold_at) begin
                while (!(bit_ready === 1'b1)) @(negedge clk);
                begin
                    int r0;
                    r0 = cap_n;
                    repeat (50) @(negedge clk);
                    // R12: a stalled stream holds the clock low
                    check(cap_n == r0 && disp_clk == 1'b0, "R12 stall", cap_n, r0);
                end
            end else begin
                repeat ($urandom_range(max_stall, 0)) @(negedge clk);
            end
            bit_valid = 1'b1; bit_data = fb[i];
            while (!(bit_ready === 1'b1)) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic run_frame(input int max_stall, input int hold_at, input bit busy_poke);
        int d0, l0, bad;
        for (int i = 0; i < FBITS; i++) fb[i] = 1'($urandom_range(1, 0));
        d0 = done_cnt; l0 = nlog;
        fork
            issue(1'b0, 8'h00, 1'b0);
            stream(max_stall, hold_at);
            begin
                if (busy_poke) begin
                    repeat (300) @(negedge clk);
                    req_valid = 1'b1; req_kind = 1'b1; req_ctl = 8'hFF;
                    repeat (40) @(negedge clk);
                    req_valid = 1'b0;
                end
            end
        join
        wait_done(d0);
        bad = 0;
        for (int i = 0; i < FBITS; i++) if (cap[i] !== fb[i]) bad++;
        check(cap_n == FBITS && log_rs[nlog-1] == 1'b0, "R7 frame edges", cap_n, FBITS);
        check(bad == 0, "R7 frame bit order", bad, 0);
        check(nlog == l0 + 1, "R10 one latch per frame", nlog - l0, 1);
        if (busy_poke) begin
            repeat (200) @(negedge clk);
            check(done_cnt == d0 + 1 && nlog == l0 + 1, "R11 request while busy",
                  done_cnt - d0, 1);
            check(req_ready == 1'b1 && disp_ce_n == 1'b1, "R11 idle after", req_ready, 1);
        end
    endtask

    task automatic run_ctl(input logic [7:0] w, input logic simul);
        int d0, l0, bad, expn;
        string tag;
        d0 = done_cnt; l0 = nlog;
        issue(1'b1, w, simul);
        wait_done(d0);
        expn = simul ? 8 : 8 * N_DEV;
        tag  = simul ? "R9 simultaneous word" : "R8 serial word";
        bad = 0;
        for (int k = 0; k < expn; k++) if (cap[k] !== cw_bit(w, k)) bad++;
        check(cap_n == expn && log_rs[nlog-1] == 1'b1, tag, cap_n, expn);
        check(bad == 0, tag, bad, 0);
        check(nlog == l0 + 1 && done_cnt == d0 + 1, "R10 latch and done", done_cnt - d0, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [7:0] iw;
        int bad;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R1: pins during reset
        check(disp_ce_n == 1'b1 && disp_clk == 1'b0 && req_ready == 1'b0, "R1 in reset",
              {disp_ce_n, disp_clk, req_ready}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(disp_ce_n == 1'b1 && disp_clk == 1'b0 && req_ready == 1'b0, "R1 after reset",
              {disp_ce_n, disp_clk, req_ready}, 3'b100);

        // R2: start-up recipe
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        iw = {1'b0, 1'b1, BRIGHT};
        check(nlog == 2, "R2 two start-up transfers", nlog, 2);
        check(log_rs[0] == 1'b0 && log_n[0] == FBITS && log_ones[0] == 0, "R2 zero frame",
              log_n[0], FBITS);
        bad = 0;
        for (int k = 0; k < 8 * N_DEV; k++) if (cap[k] !== cw_bit(iw, k)) bad++;
        check(log_rs[1] == 1'b1 && log_n[1] == 8 * N_DEV && bad == 0, "R2 wake word",
              bad, 0);
        check(done_cnt == 0, "R2 no done for start-up", done_cnt, 0);

        // directed control words
        run_ctl(8'hA5, 1'b0);
        run_ctl(8'h81, 1'b1);
        run_ctl(8'h00, 1'b0);
        run_ctl(8'hFF, 1'b1);

        // frames: directed hold, back-pressure, busy request
        run_frame(0, 100, 1'b0);
        run_frame(3, -1, 1'b1);

        // random control words
        for (int t = 0; t < 6; t++) begin
            run_ctl(8'($urandom), 1'($urandom_range(1, 0)));
        end
        run_frame(2, 5, 1'b0);

        // pin-order properties gathered over the whole run
        check(rs_moved == 0, "R3 select held while enabled", rs_moved, 0);
        check(min_rs_age >= HALF, "R3 select setup", min_rs_age, HALF);
        check(stray_rise == 0 && ce_fall_hi == 0, "R4 edges inside enable",
              stray_rise + ce_fall_hi, 0);
        check(min_hi >= HALF, "R5 high phase", min_hi, HALF);
        check(min_lo >= HALF, "R5 low phase", min_lo, HALF);
        check(din_bad == 0, "R6 data moves only at low clock", din_bad, 0);
        check(ce_rise_lo == 0, "R10 enable rises with clock high", ce_rise_lo, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule